// File: doc/BRIEF.md
# Hall Sensor Commutation Decoder

This block turns the three Hall sensor signals of a brushless DC motor into switch requests for the motor's three half-bridge legs. Each leg has one high-side request and one low-side request. A leg is either sourcing (high side on), sinking (low side on) or floating (both off). In normal running, exactly one leg sources, one leg sinks and one floats.

A single eight-entry decode covers both common sensor spacings. Codes used only by 60-degree sensors and codes used only by 120-degree sensors never overlap, so no spacing select is needed. The direction input reverses the torque by swapping source and sink. Because of this swap, the same decode also handles sensors mounted at 240 or 300 degrees.

Two controls override the decode. Enable low turns every switch off. Brake shorts the windings through the low side. The Hall signals are asynchronous, so they pass through a synchronizer first. Enable, brake and direction act combinationally. Dead time, PWM chopping and gate drive belong to the stages that follow this block.

Top module: `bldc_hall_commutator`

## Requirements
- R1: While rst_n is low, all six switch requests are low, whatever the other inputs are.
- R2: A new value on hall_in reaches the outputs exactly two rising clock edges after it is applied. After only one edge, the outputs still reflect the previous code.
- R3: Bit 0 of hs_req and ls_req is leg 1, bit 1 is leg 2 and bit 2 is leg 3. hall_in[2] is sensor 1, hall_in[1] is sensor 2 and hall_in[0] is sensor 3. When running in forward direction, each 120-degree code maps as follows:
  - 100: leg 1 sources, leg 3 sinks.
  - 110: leg 2 sources, leg 3 sinks.
  - 010: leg 2 sources, leg 1 sinks.
  - 011: leg 3 sources, leg 1 sinks.
  - 001: leg 3 sources, leg 2 sinks.
  - 101: leg 1 sources, leg 2 sinks.
- R4: The 60-degree-only codes decode like their 120-degree partners. Code 111 behaves as 010 (leg 2 sources, leg 1 sinks). Code 000 behaves as 101 (leg 1 sources, leg 2 sinks).
- R5: With dir_rev high, the legs that source and sink for a given code are exchanged. The floating leg is unchanged.
- R6: While running (enable high, brake low, out of reset), exactly one high-side request and exactly one low-side request are high, on different legs. The third leg floats.
- R7: With enable low, all six requests are low. This holds even when brake is high.
- R8: With enable high and brake high, all three low-side requests are high and all high-side requests are low, for any Hall code and direction.
- R9: No leg ever has its high-side and low-side requests high together.
- R10: Changes on enable, brake and dir_rev reach the outputs without any clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the Hall synchronizer |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 3 | Raw sensor levels; bit 2 is sensor 1, bit 0 is sensor 3 |
| dir_rev | input | 1 | High selects reverse rotation |
| enable | input | 1 | Low turns every switch off |
| brake | input | 1 | High turns on all low-side switches |
| hs_req | output | 3 | High-side switch requests, bit 0 is leg 1 |
| ls_req | output | 3 | Low-side switch requests, bit 0 is leg 1 |

## Verification
The assertions check several properties on every clock cycle: that no leg requests both switches, that enable low and brake produce their override patterns, that running produces exactly one source and one sink, and that the synchronizer output is the Hall input from two edges earlier. Only the bench scenarios can show that each Hall code selects the correct pair of legs, in both directions. They also show that the 60-degree codes fold onto the right 120-degree entries, and that a code change stays invisible after the first edge. The bench sweeps every combination of Hall code, direction, enable and brake. Its expected legs come from a rule based on sensor edges rather than from the decode table.

// File: rtl/bldc_comm_pkg.sv
// Shared types for the Hall commutation decoder.
// Assumes three motor legs; the leg state is a two-bit enum.
package bldc_comm_pkg;

    localparam int LEGS   = 3;
    localparam int HALL_W = 3;

    typedef enum logic [1:0] {
        LEG_FLOAT = 2'b00,
        LEG_SRC   = 2'b01,
        LEG_SNK   = 2'b10
    } leg_drive_e;

    typedef leg_drive_e [LEGS-1:0] leg_set_t;

    // Exchange source and sink; a floating leg stays floating.
    function automatic leg_drive_e leg_flip(input leg_drive_e d);
        case (d)
            LEG_SRC: leg_flip = LEG_SNK;
            LEG_SNK: leg_flip = LEG_SRC;
            default: leg_flip = LEG_FLOAT;
        endcase
    endfunction

endpackage

// File: rtl/hall_sync.sv
// Multi-flop synchronizer for the asynchronous Hall inputs.
// Assumes the inputs change slowly compared with clk. The latency equals STAGES edges.
module hall_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] pipe [STAGES];

    // Shift the sampled Hall code through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= d_in;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q_out = pipe[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            logic [1:0] settle;
            // Count edges since reset so the latency check never looks before reset.
            always_ff @(posedge clk) begin
                if (!rst_n)              settle <= 2'd0;
                else if (settle != 2'd2) settle <= settle + 2'd1;
            end
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                (settle == 2'd2) |-> (q_out == $past(d_in, 2))); // R2
        end
    endgenerate

endmodule

// File: rtl/comm_table.sv
// Combinational forward-direction decode of one Hall code into three leg states.
// Assumes code[2] is sensor 1 and code[0] is sensor 3. It covers both 60- and 120-degree spacing.
module comm_table
    import bldc_comm_pkg::*;
(
    input  logic [HALL_W-1:0] code,
    output leg_set_t          fwd
);

    // Map each of the eight codes to source/sink/float per leg (index 0 = leg 1).
    always_comb begin
        fwd = {LEG_FLOAT, LEG_FLOAT, LEG_FLOAT};
        case (code)
            3'b100:         fwd = {LEG_SNK,   LEG_FLOAT, LEG_SRC};
            3'b110:         fwd = {LEG_SNK,   LEG_SRC,   LEG_FLOAT};
            3'b010, 3'b111: fwd = {LEG_FLOAT, LEG_SRC,   LEG_SNK};
            3'b011:         fwd = {LEG_SRC,   LEG_FLOAT, LEG_SNK};
            3'b001:         fwd = {LEG_SRC,   LEG_SNK,   LEG_FLOAT};
            3'b101, 3'b000: fwd = {LEG_FLOAT, LEG_SNK,   LEG_SRC};
            default:        fwd = {LEG_FLOAT, LEG_FLOAT, LEG_FLOAT};
        endcase
    end

endmodule

// File: rtl/drive_arbiter.sv
// Applies direction, enable and brake to the decoded legs and splits them into switch requests.
// Priority order: reset, then enable low, then brake, then the decode.
module drive_arbiter
    import bldc_comm_pkg::*;
(
    input  logic            rst_n,
    input  logic            enable,
    input  logic            brake,
    input  logic            dir_rev,
    input  leg_set_t        fwd,
    output logic [LEGS-1:0] hs_req,
    output logic [LEGS-1:0] ls_req
);

    logic run_ok;

    // Outputs may be active only out of reset and while enabled.
    assign run_ok = rst_n && enable;

    generate
        for (genvar g = 0; g < LEGS; g++) begin : g_leg
            leg_drive_e eff;
            // Reverse direction swaps source and sink on this leg.
            assign eff = dir_rev ? leg_flip(fwd[g]) : fwd[g];
            // Brake forces the low side on and the high side off.
            assign hs_req[g] = run_ok && !brake && (eff == LEG_SRC);
            assign ls_req[g] = run_ok && (brake || (eff == LEG_SNK));
        end
    endgenerate

endmodule

// File: rtl/bldc_hall_commutator.sv
// Top level: synchronizes the Hall inputs, decodes them and drives the six switch requests.
// Assumes the downstream stages insert dead time and PWM. Control inputs act combinationally.
module bldc_hall_commutator
    import bldc_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_in,
    input  logic              dir_rev,
    input  logic              enable,
    input  logic              brake,
    output logic [LEGS-1:0]   hs_req,
    output logic [LEGS-1:0]   ls_req
);

    logic [HALL_W-1:0] hall_s;
    leg_set_t          fwd;

    hall_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (hall_in),
        .q_out (hall_s)
    );

    comm_table u_table (
        .code (hall_s),
        .fwd  (fwd)
    );

    drive_arbiter u_arb (
        .rst_n   (rst_n),
        .enable  (enable),
        .brake   (brake),
        .dir_rev (dir_rev),
        .fwd     (fwd),
        .hs_req  (hs_req),
        .ls_req  (ls_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (hs_req == '0 && ls_req == '0)); // R1
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req & ls_req) == '0); // R9
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (hs_req == '0 && ls_req == '0)); // R7
    AST_BRAKE_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && brake) |-> (ls_req == '1 && hs_req == '0)); // R8
    AST_ONE_SRC_ONE_SNK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !brake) |-> ($countones(hs_req) == 1 && $countones(ls_req) == 1)); // R6
    AST_ONE_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !brake) |-> ($countones(hs_req | ls_req) == 2)); // R6

endmodule

// File: tb/test_bldc_hall_commutator.sv
// Sweeps every Hall code, direction, enable and brake combination.
// Expected legs come from a sensor-edge rule, not from the decode table.
module test_bldc_hall_commutator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic       dir_rev = 1'b0;
    logic       enable = 1'b0;
    logic       brake = 1'b0;
    logic [2:0] hs_req;
    logic [2:0] ls_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bldc_hall_commutator i_bldc_hall_commutator (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
        .enable(enable), .brake(brake), .hs_req(hs_req), .ls_req(ls_req)
    );

    // Expected requests: source leg i has sensor i high and sensor i+1 low;
    // sink leg i has sensor i low and sensor i+1 high; 111 and 000 are fixed pairs.
    task automatic expect_of(input logic [2:0] code, input logic rev, input logic en,
                             input logic brk, output logic [2:0] ehs, output logic [2:0] els);
        logic [2:0] s;
        int hi = 0;
        int lo = 0;
        s = {code[0], code[1], code[2]};
        for (int i = 0; i < 3; i++) begin
            if (s[i] && !s[(i+1)%3]) hi = i;
            if (!s[i] && s[(i+1)%3]) lo = i;
        end
        if (code == 3'b111) begin hi = 1; lo = 0; end
        if (code == 3'b000) begin hi = 0; lo = 1; end
        if (rev) begin int t = hi; hi = lo; lo = t; end
        ehs = '0; els = '0;
        if (!en) begin
        end else if (brk) begin
            els = 3'b111;
        end else begin
            ehs[hi] = 1'b1;
            els[lo] = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [2:0] ehs, input logic [2:0] els);
        checks++;
        if (hs_req !== ehs || ls_req !== els) begin
            errors++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b (hall=%b rev=%b en=%b brk=%b)",
                     req, hs_req, ls_req, ehs, els, hall_in, dir_rev, enable, brake);
        end
        checks++;
        if ((hs_req & ls_req) != 3'b000) begin
            errors++;
            $display("FAIL R9: overlap hs=%b ls=%b expected no common bit", hs_req, ls_req);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] prev;
        logic [2:0] ehs;
        logic [2:0] els;
        string tag;
        // R1: outputs quiet during reset even with enable high.
        enable = 1'b1;
        hall_in = 3'b100;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset", 3'b000, 3'b000);
        end
        hall_in = 3'b000;
        @(negedge clk);
        rst_n = 1'b1;
        prev = 3'b000;
        for (int c = 0; c < 64; c++) begin
            logic [2:0] code;
            code = 3'(c >> 3);
            @(negedge clk);
            hall_in = code;
            dir_rev = c[0];
            brake   = c[1];
            enable  = !c[2];
            if (!enable)      tag = "R7";
            else if (brake)   tag = "R8";
            else if (code == 3'b111 || code == 3'b000) tag = "R4";
            else if (dir_rev) tag = "R5";
            else              tag = "R3";
            // After one edge: old code, new controls (R2, R10).
            @(negedge clk);
            expect_of(prev, dir_rev, enable, brake, ehs, els);
            check("R2/R10 one edge", ehs, els);
            // After two edges: new code decoded (R3-R8, R6).
            @(negedge clk);
            expect_of(code, dir_rev, enable, brake, ehs, els);
            check({tag, " R6"}, ehs, els);
            prev = code;
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule